// File: doc/BRIEF.md
# Output-Stationary Systolic Matrix Multiplier

This block multiplies two square N x N matrices of signed 8-bit integers on an N x N grid of multiply-accumulate cells. Both operand matrices are presented on wide input ports and are held steady for the whole run. A small internal counter turns them into two skewed streams. Columns of the second matrix enter along the top edge and fall one cell per clock. Rows of the first matrix enter along the left edge and move one cell to the right per clock. Each cell multiplies the two values passing through it, adds the product into its own accumulator and hands both values on to its neighbours. Lane i is delayed by i cycles, so the terms of C[i][j] meet in cell (i,j). Outside the active window the counter feeds zeros, so the accumulators are not disturbed.

After the compute phase the products stay in the cells. The grid then drains them downward along the same neighbour links, one row per clock. The bottom row is presented in parallel on the result port together with a valid strobe. A start pulse launches a run. The block reports busy until the last row has left, and it pulses done once.

Top module: `mac_grid_mm`

## Requirements
- R1: Out of reset, busy, out_valid and done are all low.
- R2: A start pulse while idle makes busy high from the next cycle on. A start pulse while busy has no effect: the timing and the results of the run in progress are unchanged.
- R3: The drained rows equal C = A x B over signed two's-complement 8-bit operands. Element (r,c) of each input matrix sits at bits [(r*N+c)*8 +: 8]. Element c of a result row sits at bits [c*AW +: AW], where AW = 16 + clog2(N).
- R4: The first cycle with out_valid high comes exactly 3N-2 cycles after the clock edge that accepted start.
- R5: out_valid stays high for exactly N consecutive cycles. The rows come out in the order N-1, N-2, ..., 0.
- R6: done is high for one cycle, in the cycle right after the last valid row. busy is low in that same cycle.
- R7: Sums of extreme operands (-128 and 127 in every position) do not overflow the accumulator. For example, with N=4, all elements at -128 give 65536 in every result.
- R8: Every run starts from cleared accumulators. A run launched right after done returns only its own product.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Launch pulse, accepted only when idle |
| a_mat | input | N*N*8 | Left-edge operand matrix A, row-major |
| b_mat | input | N*N*8 | Top-edge operand matrix B, row-major |
| busy | output | 1 | High from start until the last row is out |
| done | output | 1 | One-cycle pulse at the end of a run |
| out_valid | output | 1 | High while a result row is presented |
| res_row | output | N*AW | One row of C, element c at [c*AW +: AW] |

## Verification
Two cases are hard to reach from the ports. The first is the end of the skew window, where the last real operand pair meets in the corner cell on the final compute cycle. An error of one cycle there corrupts only C[N-1][N-1], so every run compares each element of each row against a product computed independently in the bench. The second case is a start that arrives mid-run. The bench pulses start once during compute and once during drain, then checks that the latency, the row count and the results match an undisturbed run. Runs with all operands at -128 and with mixed 127/-128 operands, launched back to back, check both the accumulator width and the clearing on start.

// File: rtl/mac_grid_mm.sv
module mac_grid_mm #(
  parameter int N  = 4,
  parameter int DW = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [N*N*DW-1:0] a_mat,
  input  logic [N*N*DW-1:0] b_mat,
  output logic              busy,
  output logic              done,
  output logic              out_valid,
  output logic [N*(2*DW+$clog2(N))-1:0] res_row
);
  localparam int AW = 2*DW + $clog2(N);
  localparam int CW = $clog2(3*N);
  localparam logic [CW-1:0] LAST_COMP  = CW'(3*N-3);
  localparam logic [CW-1:0] LAST_DRAIN = CW'(N-1);

  typedef enum logic [1:0] {IDLE, COMP, DRAIN} st_t;
  st_t st;
  logic [CW-1:0] cnt;

  logic signed [DW-1:0] feed_a [N];
  logic signed [DW-1:0] feed_b [N];
  logic signed [DW-1:0] a_reg  [N][N];
  logic signed [DW-1:0] b_reg  [N][N];
  logic signed [AW-1:0] acc    [N][N];
  logic signed [DW-1:0] a_in   [N][N];
  logic signed [DW-1:0] b_in   [N][N];
  logic signed [AW-1:0] above  [N][N];

  always_comb begin
    for (int i = 0; i < N; i++) begin
      int k;
      k = int'(cnt) - i;
      feed_a[i] = '0;
      feed_b[i] = '0;
      if (st == COMP && k >= 0 && k < N) begin
        feed_a[i] = a_mat[(i*N+k)*DW +: DW];
        feed_b[i] = b_mat[(k*N+i)*DW +: DW];
      end
    end
  end

  for (genvar r = 0; r < N; r++) begin : g_row
    for (genvar c = 0; c < N; c++) begin : g_col
      if (c == 0) begin : g_ledge
        assign a_in[r][c] = feed_a[r];
      end else begin : g_lin
        assign a_in[r][c] = a_reg[r][c-1];
      end
      if (r == 0) begin : g_tedge
        assign b_in[r][c]  = feed_b[c];
        assign above[r][c] = '0;
      end else begin : g_tin
        assign b_in[r][c]  = b_reg[r-1][c];
        assign above[r][c] = acc[r-1][c];
      end
    end
  end

  for (genvar c = 0; c < N; c++) begin : g_out
    assign res_row[c*AW +: AW] = acc[N-1][c];
  end

  assign busy      = (st != IDLE);
  assign out_valid = (st == DRAIN);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st   <= IDLE;
      cnt  <= '0;
      done <= 1'b0;
    end else begin
      done <= 1'b0;
      case (st)
        IDLE: if (start) begin
          st  <= COMP;
          cnt <= '0;
        end
        COMP: if (cnt == LAST_COMP) begin
          st  <= DRAIN;
          cnt <= '0;
        end else cnt <= cnt + 1'b1;
        DRAIN: if (cnt == LAST_DRAIN) begin
          st   <= IDLE;
          cnt  <= '0;
          done <= 1'b1;
        end else cnt <= cnt + 1'b1;
        default: st <= IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int r = 0; r < N; r++)
        for (int c = 0; c < N; c++) begin
          a_reg[r][c] <= '0;
          b_reg[r][c] <= '0;
          acc[r][c]   <= '0;
        end
    end else begin
      for (int r = 0; r < N; r++)
        for (int c = 0; c < N; c++) begin
          if (st == IDLE && start) begin
            a_reg[r][c] <= '0;
            b_reg[r][c] <= '0;
            acc[r][c]   <= '0;
          end else if (st == COMP) begin
            a_reg[r][c] <= a_in[r][c];
            b_reg[r][c] <= b_in[r][c];
            acc[r][c]   <= acc[r][c] + AW'(a_in[r][c]) * AW'(b_in[r][c]);
          end else if (st == DRAIN) begin
            acc[r][c]   <= above[r][c];
          end
        end
    end
  end
endmodule

// File: rtl/mac_grid_mm_chk.sv
module mac_grid_mm_chk #(
  parameter int N = 4
) (
  input logic clk,
  input logic rst_n,
  input logic start,
  input logic busy,
  input logic done,
  input logic out_valid
);
  int lat_cnt;
  int run_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lat_cnt <= 0;
      run_cnt <= 0;
    end else begin
      lat_cnt <= !busy ? 0 : (out_valid ? lat_cnt : lat_cnt + 1);
      run_cnt <= out_valid ? run_cnt + 1 : 0;
    end
  end

  // R1
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !out_valid);

  // R2
  start_launch_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(start));

  // R2
  busy_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !out_valid) |=> busy);

  // R4
  latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(out_valid) |-> (lat_cnt == 3*N-2));

  // R5
  run_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(out_valid) |-> (run_cnt == N));

  // R6
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R6
  done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);

  // R6
  drain_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(out_valid) |-> done);
endmodule

bind mac_grid_mm mac_grid_mm_chk #(.N(N)) u_chk (
  .clk(clk), .rst_n(rst_n), .start(start),
  .busy(busy), .done(done), .out_valid(out_valid)
);

// File: tb/mac_grid_mm_bench.sv
module mac_grid_mm_bench;
  localparam int N  = 4;
  localparam int DW = 8;
  localparam int AW = 2*DW + $clog2(N);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic [N*N*DW-1:0] a_mat = '0;
  logic [N*N*DW-1:0] b_mat = '0;
  logic busy, done, out_valid;
  logic [N*AW-1:0] res_row;

  int checks = 0;
  int fails  = 0;
  int ma [N][N];
  int mb [N][N];
  logic [N*AW-1:0] exp_q [$];

  always #4 clk = ~clk;

  mac_grid_mm #(.N(N), .DW(DW)) u_mac_grid_mm (
    .clk(clk), .rst_n(rst_n), .start(start), .a_mat(a_mat), .b_mat(b_mat),
    .busy(busy), .done(done), .out_valid(out_valid), .res_row(res_row)
  );

  task automatic check(input string req, input longint act, input longint expv);
    checks++;
    if (act != expv) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, expv);
    end
  endtask

  // monitor: R3 / R5 row order and values
  always @(negedge clk) begin
    if (rst_n && out_valid) begin
      if (exp_q.size() == 0) begin
        check("R5 unexpected row", 1, 0);
      end else begin
        logic [N*AW-1:0] e;
        e = exp_q.pop_front();
        for (int c = 0; c < N; c++)
          check("R3 element", longint'($signed(res_row[c*AW +: AW])),
                longint'($signed(e[c*AW +: AW])));
      end
    end
  end

  task automatic load_and_expect();
    for (int r = 0; r < N; r++)
      for (int c = 0; c < N; c++) begin
        a_mat[(r*N+c)*DW +: DW] = DW'(ma[r][c]);
        b_mat[(r*N+c)*DW +: DW] = DW'(mb[r][c]);
      end
    for (int r = N-1; r >= 0; r--) begin
      logic [N*AW-1:0] row;
      for (int c = 0; c < N; c++) begin
        longint s;
        s = 0;
        for (int k = 0; k < N; k++) s += longint'(ma[r][k]) * longint'(mb[k][c]);
        row[c*AW +: AW] = AW'(s);
      end
      exp_q.push_back(row);
    end
  endtask

  task automatic run(input bit glitch);
    int k;
    int nv;
    load_and_expect();
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    check("R2 busy after start", busy, 1);
    k = 0;
    while (!out_valid && k < 100) begin
      start = (glitch && k == 3);
      @(negedge clk);
      k++;
    end
    start = 1'b0;
    check("R4 latency", k, 3*N-2);
    nv = 0;
    while (out_valid && nv < 100) begin
      start = (glitch && nv == 1);
      @(negedge clk);
      nv++;
    end
    start = 1'b0;
    check("R5 valid run length", nv, N);
    check("R6 done pulse", done, 1);
    check("R6 busy low at done", busy, 0);
    check("R5 all rows drained", exp_q.size(), 0);
    @(negedge clk);
    check("R6 done single cycle", done, 0);
    check("R2 stray start ignored", busy, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check("R1 busy at reset", busy, 0);
    check("R1 out_valid at reset", out_valid, 0);
    check("R1 done at reset", done, 0);
    rst_n = 1'b1;
    @(negedge clk);

    // R3 identity times random
    for (int r = 0; r < N; r++)
      for (int c = 0; c < N; c++) begin
        ma[r][c] = (r == c) ? 1 : 0;
        mb[r][c] = int'($urandom_range(255)) - 128;
      end
    run(0);

    // R3 random products
    for (int t = 0; t < 4; t++) begin
      for (int r = 0; r < N; r++)
        for (int c = 0; c < N; c++) begin
          ma[r][c] = int'($urandom_range(255)) - 128;
          mb[r][c] = int'($urandom_range(255)) - 128;
        end
      run(0);
    end

    // R2 start pulses during compute and drain
    run(1);

    // R7 all -128
    for (int r = 0; r < N; r++)
      for (int c = 0; c < N; c++) begin
        ma[r][c] = -128;
        mb[r][c] = -128;
      end
    run(0);

    // R7 mixed 127 / -128
    for (int r = 0; r < N; r++)
      for (int c = 0; c < N; c++) begin
        ma[r][c] = ((r + c) % 2 == 0) ? 127 : -128;
        mb[r][c] = (r % 2 == 0) ? -128 : 127;
      end
    run(0);

    // R8 small product right after the large one: no leftover sums
    for (int r = 0; r < N; r++)
      for (int c = 0; c < N; c++) begin
        ma[r][c] = r + 1;
        mb[r][c] = (c == 0) ? 1 : 0;
      end
    run(0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule